// File: doc/BRIEF.md
# Nine-Bit Serial Transmitter with Internal Loopback

This block turns characters into an asynchronous serial bit stream. Software-side logic writes a character into a one-entry holding buffer. When the serializer is idle, the character moves into a shift register. The serializer then sends a low start bit, the data bits least significant first, and a high stop period. Each bit lasts a fixed number of pulses of an oversampling tick that an external baud generator supplies. With the default of 16 pulses per bit, a 7/8 stop period lasts 14 pulses. The frame carries nine data bits. A control input can drop the top data bit to give eight. The framing options are captured when a character moves from the buffer into the shift register.

A two-bit loopback control selects a diagnostic path when both of its bits are set. The serial stream then goes to an internal output that feeds the receiver, and the external pin rests high. Loopback always uses nine data bits.

A one-cycle low-power entry pulse stops any frame in progress and fills the shift register with ones. It marks the buffer empty and clears the busy status. The buffer contents and the control inputs are not changed by it.

Top module: `nine_bit_uart_tx`

## Requirements
- R1: After reset the pin output and the loopback output are high, the empty flag `tbmt_o` is 1 and `busy_o` is 0. Whenever the block is not busy, the serial line is high.
- R2: A write clears `tbmt_o` in the following cycle. If the serializer is idle, the character moves to the shift register on the next clock. At that clock `tbmt_o` returns to 1 and `busy_o` becomes 1.
- R3: A frame begins with a low start bit of 16 tick pulses. Each data bit follows for 16 tick pulses, least significant bit first. The line changes only on a tick pulse or on low-power entry.
- R4: When `nine_bit_i` is 1, the frame carries data bits 0 to 8, with bit 8 last before the stop period. When it is 0, the frame carries bits 0 to 7.
- R5: The stop period is high. Its length is set by `stop_sel_i`: 0 gives 14 tick pulses (7/8 bit), 1 gives 16, 2 gives 32, and 3 also gives 32. `busy_o` falls at the last stop pulse.
- R6: When `loop_i` is 2'b11, `loop_rx_o` carries the serial stream and `tx_o` is held high. For any other value, `tx_o` carries the stream and `loop_rx_o` is held high.
- R7: In loopback the frame carries nine data bits whatever `nine_bit_i` is.
- R8: In the cycle after a `lowpwr_i` pulse, `tbmt_o` is 1, `busy_o` is 0 and the line is high. Any frame in progress is dropped, and a character that was waiting in the buffer is not sent.
- R9: A character written during a frame waits in the buffer with `tbmt_o` at 0. It starts one clock after the last stop pulse, so that consecutive frames follow each other back to back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_i | input | 1 | Oversampling tick pulse, 16 per bit time |
| wr_i | input | 1 | Write strobe for the holding buffer |
| wr_data_i | input | 9 | Character to send |
| nine_bit_i | input | 1 | 1 sends nine data bits, 0 sends eight |
| stop_sel_i | input | 2 | Stop length code (0: 7/8, 1: one, 2 or 3: two bits) |
| loop_i | input | 2 | Loopback control; 2'b11 enables the internal path |
| lowpwr_i | input | 1 | One-cycle pulse on low-power entry |
| tx_o | output | 1 | External serial pin |
| loop_rx_o | output | 1 | Internal serial path to the receiver |
| tbmt_o | output | 1 | Holding buffer empty flag |
| busy_o | output | 1 | Frame in progress |

## Verification
The hardest situations to reach are low-power entry in the middle of a frame and low-power entry while a second character waits in the buffer behind a running frame. The stimulus writes two characters back to back and pulses `lowpwr_i` while the first is still shifting. It then confirms that the waiting character never appears on the line. The tick pulse is also slowed to one pulse every three clocks, so that frame ends do not coincide with clock-aligned events. Under that slow tick, the 7/8 and two-bit stop lengths are separated from each other by counting cycles.

// File: rtl/utx_pkg.sv
package utx_pkg;

   typedef enum logic [1:0] {
      SH_IDLE = 2'd0,
      SH_DATA = 2'd1,
      SH_STOP = 2'd2
   } sh_state_e;

   typedef enum logic [1:0] {
      STOP_FRAC = 2'd0,
      STOP_ONE  = 2'd1,
      STOP_TWO  = 2'd2,
      STOP_TWOB = 2'd3
   } stop_code_e;

   function automatic int unsigned stop_span(input stop_code_e code,
                                             input int unsigned osr,
                                             input int unsigned frac);
      case (code)
         STOP_FRAC: return frac;
         STOP_ONE:  return osr;
         default:   return 2 * osr;
      endcase
   endfunction

endpackage

// File: rtl/utx_hold.sv
module utx_hold #(
   parameter int unsigned DW = 9
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          wr_i,
   input  logic [DW-1:0] wr_data_i,
   input  logic          lowpwr_i,
   input  logic          take_i,
   output logic [DW-1:0] data_o,
   output logic          empty_o
);

   logic [DW-1:0] hold_q;
   logic          empty_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         hold_q  <= '0;
         empty_q <= 1'b1;
      end else begin
         if (wr_i && !lowpwr_i)
            hold_q <= wr_data_i;
         if (lowpwr_i)
            empty_q <= 1'b1;
         else if (wr_i)
            empty_q <= 1'b0;
         else if (take_i)
            empty_q <= 1'b1;
      end
   end

   assign data_o  = hold_q;
   assign empty_o = empty_q;

endmodule

// File: rtl/utx_serializer.sv
module utx_serializer
   import utx_pkg::*;
#(
   parameter int unsigned DW   = 9,
   parameter int unsigned OSR  = 16,
   parameter int unsigned FRAC = 14
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          tick_i,
   input  logic          load_i,
   input  logic [DW-1:0] data_i,
   input  logic          full_len_i,
   input  logic [1:0]    stop_code_i,
   input  logic          lowpwr_i,
   output logic          ser_o,
   output logic          idle_o
);

   localparam int unsigned SW = DW + 1;
   localparam int unsigned CW = $clog2(2 * OSR);
   localparam int unsigned BW = $clog2(DW + 2);

   localparam logic [CW-1:0] LAST_TICK = CW'(OSR - 1);
   localparam logic [BW-1:0] LEN_FULL  = BW'(DW + 1);
   localparam logic [BW-1:0] LEN_SHORT = BW'(DW);

   sh_state_e     state_q;
   logic [SW-1:0] sft_q;
   logic [CW-1:0] tcnt_q;
   logic [BW-1:0] left_q;
   stop_code_e    stop_q;
   logic [CW-1:0] stop_last;
   logic          top_bit;

   assign top_bit   = full_len_i ? data_i[DW-1] : 1'b1;
   assign stop_last = CW'(stop_span(stop_q, OSR, FRAC) - 1);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q <= SH_IDLE;
         sft_q   <= '1;
         tcnt_q  <= '0;
         left_q  <= '0;
         stop_q  <= STOP_ONE;
      end else if (lowpwr_i) begin
         state_q <= SH_IDLE;
         sft_q   <= '1;
         tcnt_q  <= '0;
         left_q  <= '0;
      end else begin
         case (state_q)
            SH_IDLE: begin
               if (load_i) begin
                  sft_q   <= {top_bit, data_i[DW-2:0], 1'b0};
                  left_q  <= full_len_i ? LEN_FULL : LEN_SHORT;
                  stop_q  <= stop_code_e'(stop_code_i);
                  tcnt_q  <= '0;
                  state_q <= SH_DATA;
               end
            end
            SH_DATA: begin
               if (tick_i) begin
                  if (tcnt_q == LAST_TICK) begin
                     tcnt_q <= '0;
                     sft_q  <= {1'b1, sft_q[SW-1:1]};
                     if (left_q == BW'(1)) begin
                        sft_q   <= '1;
                        state_q <= SH_STOP;
                     end
                     left_q <= left_q - BW'(1);
                  end else begin
                     tcnt_q <= tcnt_q + CW'(1);
                  end
               end
            end
            SH_STOP: begin
               if (tick_i) begin
                  if (tcnt_q == stop_last) begin
                     tcnt_q  <= '0;
                     state_q <= SH_IDLE;
                  end else begin
                     tcnt_q <= tcnt_q + CW'(1);
                  end
               end
            end
            default: state_q <= SH_IDLE;
         endcase
      end
   end

   assign ser_o  = sft_q[0];
   assign idle_o = (state_q == SH_IDLE);

endmodule

// File: rtl/utx_route.sv
module utx_route #(
   parameter bit HAS_LOOP = 1'b1
) (
   input  logic       ser_i,
   input  logic [1:0] loop_sel_i,
   output logic       tx_o,
   output logic       rx_loop_o,
   output logic       loop_on_o
);

   generate
      if (HAS_LOOP) begin : g_loop
         assign loop_on_o = &loop_sel_i;
      end else begin : g_noloop
         logic unused_sel;
         assign unused_sel = ^loop_sel_i;
         assign loop_on_o  = 1'b0;
      end
   endgenerate

   assign tx_o      = loop_on_o ? 1'b1 : ser_i;
   assign rx_loop_o = loop_on_o ? ser_i : 1'b1;

endmodule

// File: rtl/nine_bit_uart_tx.sv
module nine_bit_uart_tx #(
   parameter int unsigned DW       = 9,
   parameter int unsigned OSR      = 16,
   parameter int unsigned FRAC     = 14,
   parameter bit          HAS_LOOP = 1'b1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          tick_i,
   input  logic          wr_i,
   input  logic [DW-1:0] wr_data_i,
   input  logic          nine_bit_i,
   input  logic [1:0]    stop_sel_i,
   input  logic [1:0]    loop_i,
   input  logic          lowpwr_i,
   output logic          tx_o,
   output logic          loop_rx_o,
   output logic          tbmt_o,
   output logic          busy_o
);

   generate
      if (DW < 2) begin : g_bad_dw
         $error("nine_bit_uart_tx: DW must be at least 2");
      end
      if (OSR < 2) begin : g_bad_osr
         $error("nine_bit_uart_tx: OSR must be at least 2");
      end
      if (FRAC == 0 || FRAC >= OSR) begin : g_bad_frac
         $error("nine_bit_uart_tx: FRAC must lie between 1 and OSR-1");
      end
   endgenerate

   logic [DW-1:0] hold_data;
   logic          hold_empty;
   logic          sh_idle;
   logic          take;
   logic          ser_line;
   logic          loop_on;
   logic          full_len;

   assign take     = sh_idle && !hold_empty && !lowpwr_i;
   assign full_len = nine_bit_i || loop_on;

   utx_hold #(.DW(DW)) u_hold (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_i      (wr_i),
      .wr_data_i (wr_data_i),
      .lowpwr_i  (lowpwr_i),
      .take_i    (take),
      .data_o    (hold_data),
      .empty_o   (hold_empty)
   );

   utx_serializer #(.DW(DW), .OSR(OSR), .FRAC(FRAC)) u_ser (
      .clk         (clk),
      .rst_n       (rst_n),
      .tick_i      (tick_i),
      .load_i      (take),
      .data_i      (hold_data),
      .full_len_i  (full_len),
      .stop_code_i (stop_sel_i),
      .lowpwr_i    (lowpwr_i),
      .ser_o       (ser_line),
      .idle_o      (sh_idle)
   );

   utx_route #(.HAS_LOOP(HAS_LOOP)) u_route (
      .ser_i      (ser_line),
      .loop_sel_i (loop_i),
      .tx_o       (tx_o),
      .rx_loop_o  (loop_rx_o),
      .loop_on_o  (loop_on)
   );

   assign tbmt_o = hold_empty;
   assign busy_o = !sh_idle;

endmodule

// File: rtl/nine_bit_uart_tx_chk.sv
module nine_bit_uart_tx_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       tick_i,
   input logic       wr_i,
   input logic       lowpwr_i,
   input logic [1:0] loop_i,
   input logic       tx_o,
   input logic       loop_rx_o,
   input logic       tbmt_o,
   input logic       busy_o,
   input logic       ser_line
);

   // R1
   idle_line_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !busy_o |-> ser_line);

   // R2
   write_clears_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_i && !lowpwr_i) |=> !tbmt_o);

   // R2
   empty_sets_on_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(tbmt_o) |-> ($rose(busy_o) || $past(lowpwr_i)));

   // R3
   start_bit_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy_o) |-> !ser_line);

   // R3
   line_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_o && !tick_i && !lowpwr_i) |=> $stable(ser_line));

   // R6
   loop_pin_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (loop_i == 2'b11) |-> (tx_o && (loop_rx_o == ser_line)));

   // R6
   normal_path_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (loop_i != 2'b11) |-> (loop_rx_o && (tx_o == ser_line)));

   // R8
   lowpower_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
      lowpwr_i |=> (tbmt_o && !busy_o && ser_line));

endmodule

bind nine_bit_uart_tx nine_bit_uart_tx_chk u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .tick_i    (tick_i),
   .wr_i      (wr_i),
   .lowpwr_i  (lowpwr_i),
   .loop_i    (loop_i),
   .tx_o      (tx_o),
   .loop_rx_o (loop_rx_o),
   .tbmt_o    (tbmt_o),
   .busy_o    (busy_o),
   .ser_line  (ser_line)
);

// File: tb/nine_bit_uart_tx_test.sv
module nine_bit_uart_tx_test;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       tick_i = 1'b0;
   logic       wr_i = 1'b0;
   logic [8:0] wr_data_i = '0;
   logic       nine_bit_i = 1'b1;
   logic [1:0] stop_sel_i = 2'd1;
   logic [1:0] loop_i = 2'd0;
   logic       lowpwr_i = 1'b0;
   logic       tx_o, loop_rx_o, tbmt_o, busy_o;

   int checks = 0;
   int errors = 0;
   int tdiv = 1;
   int tcnt = 0;
   int cycles = 0;
   string cur_req = "R1";

   // reference model state
   int         q[$];
   bit         m_tbmt = 1'b1;
   logic [8:0] m_buf = '0;

   always #2 clk = ~clk;

   nine_bit_uart_tx uut (
      .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .wr_i(wr_i),
      .wr_data_i(wr_data_i), .nine_bit_i(nine_bit_i), .stop_sel_i(stop_sel_i),
      .loop_i(loop_i), .lowpwr_i(lowpwr_i), .tx_o(tx_o), .loop_rx_o(loop_rx_o),
      .tbmt_o(tbmt_o), .busy_o(busy_o)
   );

   task automatic check(string req, string what, int act, int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s %s: actual %0d expected %0d at cycle %0d", req, what, act, exp, cycles);
      end
   endtask

   // tick generator
   always @(negedge clk) begin
      if (tcnt >= tdiv - 1) begin
         tick_i = 1'b1;
         tcnt = 0;
      end else begin
         tick_i = 1'b0;
         tcnt = tcnt + 1;
      end
   end

   // behavioural reference model
   always @(posedge clk) begin
      cycles++;
      if (!rst_n) begin
         q.delete();
         m_tbmt = 1'b1;
         m_buf = '0;
      end else if (lowpwr_i) begin
         q.delete();
         m_tbmt = 1'b1;
      end else begin
         bit do_load;
         do_load = (q.size() == 0) && !m_tbmt;
         if (tick_i && q.size() > 0) void'(q.pop_front());
         if (do_load) begin
            int nb;
            int sl;
            nb = (nine_bit_i || loop_i == 2'b11) ? 9 : 8;
            sl = (stop_sel_i == 2'd0) ? 14 : (stop_sel_i == 2'd1) ? 16 : 32;
            for (int k = 0; k < 16; k++) q.push_back(0);
            for (int b = 0; b < nb; b++)
               for (int k = 0; k < 16; k++) q.push_back(int'(m_buf[b]));
            for (int k = 0; k < sl; k++) q.push_back(1);
            m_tbmt = 1'b1;
         end
         if (wr_i) begin
            m_buf = wr_data_i;
            m_tbmt = 1'b0;
         end
      end
   end

   // per-cycle comparison, after the edge and before inputs move
   always begin
      @(posedge clk);
      #1;
      if (rst_n) begin
         int line;
         line = (q.size() > 0) ? q[0] : 1;
         check(cur_req, "tx_o", int'(tx_o), (loop_i == 2'b11) ? 1 : line);
         check(cur_req, "loop_rx_o", int'(loop_rx_o), (loop_i == 2'b11) ? line : 1);
         check(cur_req, "tbmt_o", int'(tbmt_o), int'(m_tbmt));
         check(cur_req, "busy_o", int'(busy_o), (q.size() > 0) ? 1 : 0);
      end
   end

   // watchdog
   initial begin
      repeat (150000) @(posedge clk);
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   task automatic write_char(logic [8:0] v);
      @(negedge clk);
      wr_i = 1'b1;
      wr_data_i = v;
      @(negedge clk);
      wr_i = 1'b0;
   endtask

   task automatic wait_idle();
      for (int n = 0; n < 4000; n++) begin
         @(negedge clk);
         if (!busy_o && tbmt_o) break;
      end
      @(negedge clk);
   endtask

   task automatic pulse_lowpwr();
      @(negedge clk);
      lowpwr_i = 1'b1;
      @(negedge clk);
      lowpwr_i = 1'b0;
   endtask

   initial begin
      repeat (3) @(negedge clk);
      // R1 reset state
      check("R1", "tx_o reset", int'(tx_o), 1);
      check("R1", "loop_rx_o reset", int'(loop_rx_o), 1);
      check("R1", "tbmt_o reset", int'(tbmt_o), 1);
      check("R1", "busy_o reset", int'(busy_o), 0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);

      // R2 and R3: nine-bit frame, one stop bit, tick every clock
      cur_req = "R2";
      write_char(9'h1A5);
      check("R2", "tbmt_o after write", int'(tbmt_o), 0);
      @(negedge clk);
      check("R2", "tbmt_o after transfer", int'(tbmt_o), 1);
      check("R2", "busy_o after transfer", int'(busy_o), 1);
      check("R3", "start bit", int'(tx_o), 0);
      cur_req = "R3";
      wait_idle();

      // R4 eight-bit frame
      cur_req = "R4";
      nine_bit_i = 1'b0;
      write_char(9'h1F3);
      wait_idle();
      nine_bit_i = 1'b1;
      write_char(9'h100);
      wait_idle();

      // R5 stop lengths under a slow tick
      cur_req = "R5";
      tdiv = 3;
      for (int s = 0; s < 4; s++) begin
         stop_sel_i = 2'(s);
         write_char(9'h0C3 + 9'(s));
         wait_idle();
      end
      stop_sel_i = 2'd1;

      // R9 back-to-back frames
      cur_req = "R9";
      tdiv = 2;
      write_char(9'h155);
      write_char(9'h0AA);
      check("R9", "tbmt_o while waiting", int'(tbmt_o), 0);
      wait_idle();

      // R6 and R7 loopback, eight-bit request overridden
      cur_req = "R7";
      tdiv = 1;
      loop_i = 2'b11;
      nine_bit_i = 1'b0;
      write_char(9'h1E1);
      repeat (20) @(negedge clk);
      check("R6", "tx_o held in loopback", int'(tx_o), 1);
      wait_idle();
      cur_req = "R6";
      loop_i = 2'b01;
      write_char(9'h05A);
      wait_idle();
      loop_i = 2'b10;
      write_char(9'h13C);
      wait_idle();
      loop_i = 2'b00;
      nine_bit_i = 1'b1;

      // R8 low-power entry mid-frame
      cur_req = "R8";
      write_char(9'h000);
      repeat (40) @(negedge clk);
      pulse_lowpwr();
      check("R8", "tbmt_o after entry", int'(tbmt_o), 1);
      check("R8", "busy_o after entry", int'(busy_o), 0);
      check("R8", "tx_o after entry", int'(tx_o), 1);
      repeat (10) @(negedge clk);

      // R8 waiting character discarded
      write_char(9'h0F0);
      write_char(9'h00F);
      repeat (5) @(negedge clk);
      check("R8", "tbmt_o with waiting char", int'(tbmt_o), 0);
      pulse_lowpwr();
      check("R8", "tbmt_o after entry with waiting char", int'(tbmt_o), 1);
      repeat (60) @(negedge clk);
      check("R8", "busy_o stays low", int'(busy_o), 0);
      check("R8", "tx_o stays high", int'(tx_o), 1);

      // after low power the block still sends normally
      cur_req = "R3";
      write_char(9'h0A5);
      wait_idle();

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule